// File: doc/BRIEF.md
# Pipelined Tightly-Coupled Memory Slave

This block is an on-chip memory that answers a pipelined processor-side bus without a handshake in the usual sense. The processor presents an access in a single request cycle (select, byte address, direction, byte-lane enables and store data all valid together). The slave then takes one or more data cycles to finish it. A wait output tells the processor, one cycle ahead, whether the access finishes in the following cycle. Load data is presented in the closing data cycle.

The number of extra data cycles is chosen per access by a 3-bit run-time input, read only in the request cycle. With a setting of zero, wait never rises, and a new request can sit in the closing data cycle of the previous one. This gives one access per clock. Storage is an internal synchronous RAM, one byte-wide bank per lane. Stores are committed at the end of the request cycle. Loads are read at that same edge into a registered output, which holds until the next load.

Top module: `tcm_slave`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, `tcm_wait` is low and `tcm_rdata` is zero (provided no request is presented).
- R2: With a wait setting W from 1 to 7 sampled in the request cycle, the access has W+1 data cycles. `tcm_wait` is high in the request cycle and in data cycles 1 to W-1. It is low in data cycle W, and the access ends in data cycle W+1.
- R3: With W = 0, `tcm_wait` stays low in the request cycle, and the single following cycle is the closing data cycle. A new request may be presented in that cycle, so back-to-back accesses run at one per clock.
- R4: For a load, `tcm_rdata` carries the addressed word from the first data cycle through the closing data cycle.
- R5: A store writes only the byte lanes whose enable is set. Enable bit i covers data bits [8i+7:8i]. Bytes of disabled lanes keep their old value.
- R6: Address, direction, lanes and store data are taken only in the request cycle. Whatever is driven on them during later data cycles does not change the access.
- R7: With the default depth of 1024 words, the word index is address bits [11:2]. Bits [1:0] and [17:12] are ignored, so addresses that differ only there reach the same word.
- R8: Changing the wait setting during data cycles does not alter the wait pattern of the access in flight.
- R9: In a cycle with no request that follows a cycle where `tcm_wait` was low (idle or closing data cycle), `tcm_wait` is low.
- R10: A store leaves `tcm_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tcm_sel | input | 1 | Request cycle marker (chip select) |
| tcm_addr | input | 18 | Byte address, valid in the request cycle |
| tcm_write | input | 1 | 1 = store, 0 = load; valid in the request cycle |
| tcm_lanes | input | 4 | Byte-lane enables for stores; bit i covers data bits [8i+7:8i] |
| tcm_wdata | input | 32 | Store data, valid in the request cycle |
| wait_cfg | input | 3 | Extra data cycles for the access being requested (0 to 7) |
| tcm_wait | output | 1 | High: the access does not complete in the next cycle |
| tcm_rdata | output | 32 | Load data, valid in the closing data cycle |

## Verification
The assertions assume the processor respects the pipeline. A request is raised only in a cycle whose predecessor had `tcm_wait` low, which means only in an idle cycle or in the closing data cycle of the previous access. No request is ever raised during reset. The stimulus follows this by issuing each request only after stepping through exactly the number of data cycles set by that request's wait setting. In the data cycles between requests it drives select low and puts random values on address, direction, lanes, store data and wait setting.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int TCM_ADDR_W = 18;
  localparam int TCM_DATA_W = 32;
  localparam int TCM_LANE_W = 8;
  localparam int TCM_WAIT_W = 3;
endpackage

// File: rtl/tcm_wait_ctrl.sv
module tcm_wait_ctrl #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [WAIT_W-1:0] cfg_i,
  output logic              wait_o
);
  // cycles still to run after the current data cycle
  logic [WAIT_W-1:0] left_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (req_i) begin
      busy_q <= 1'b1;
      left_q <= cfg_i;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  // Combinational by protocol: the answer belongs to the request cycle itself.
  assign wait_o = (req_i && (cfg_i != '0)) ||
                  (busy_q && (left_q > WAIT_W'(1)));
endmodule

// File: rtl/tcm_lane_ram.sv
module tcm_lane_ram #(
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int WORDS_LOG2 = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lane_i,
  input  logic [WORDS_LOG2-1:0]   idx_i,
  input  logic [LANES*LANE_W-1:0] wd_i,
  output logic [LANES*LANE_W-1:0] rd_o
);
  localparam int DEPTH = 1 << WORDS_LOG2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] out_q;

    always_ff @(posedge clk) begin
      if (en_i && we_i && lane_i[g])
        bank[idx_i] <= wd_i[g*LANE_W +: LANE_W];
      if (rst)
        out_q <= '0;
      else if (en_i && !we_i)
        out_q <= bank[idx_i];
    end

    assign rd_o[g*LANE_W +: LANE_W] = out_q;
  end
endmodule

// File: rtl/tcm_slave.sv
module tcm_slave
  import tcm_pkg::*;
#(
  parameter int ADDR_W     = TCM_ADDR_W,
  parameter int DATA_W     = TCM_DATA_W,
  parameter int LANE_W     = TCM_LANE_W,
  parameter int WAIT_W     = TCM_WAIT_W,
  parameter int WORDS_LOG2 = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tcm_sel,
  input  logic [ADDR_W-1:0]        tcm_addr,
  input  logic                     tcm_write,
  input  logic [DATA_W/LANE_W-1:0] tcm_lanes,
  input  logic [DATA_W-1:0]        tcm_wdata,
  input  logic [WAIT_W-1:0]        wait_cfg,
  output logic                     tcm_wait,
  output logic [DATA_W-1:0]        tcm_rdata
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_HI = OFF_W + WORDS_LOG2;

  logic [WORDS_LOG2-1:0] word_idx;
  logic                  unused_addr;

  assign word_idx    = tcm_addr[OFF_W +: WORDS_LOG2];
  assign unused_addr = ^{tcm_addr[OFF_W-1:0], tcm_addr[ADDR_W-1:IDX_HI]};

  tcm_wait_ctrl #(
    .WAIT_W (WAIT_W)
  ) u_wait (
    .clk    (clk),
    .rst    (rst),
    .req_i  (tcm_sel),
    .cfg_i  (wait_cfg),
    .wait_o (tcm_wait)
  );

  tcm_lane_ram #(
    .LANES      (LANES),
    .LANE_W     (LANE_W),
    .WORDS_LOG2 (WORDS_LOG2)
  ) u_ram (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tcm_sel),
    .we_i   (tcm_write),
    .lane_i (tcm_lanes),
    .idx_i  (word_idx),
    .wd_i   (tcm_wdata),
    .rd_o   (tcm_rdata)
  );
endmodule

// File: rtl/tcm_slave_chk.sv
module tcm_slave_chk #(
  parameter int WAIT_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tcm_sel,
  input logic              tcm_write,
  input logic [WAIT_W-1:0] wait_cfg,
  input logic              tcm_wait,
  input logic [DATA_W-1:0] tcm_rdata
);
  assert_zero_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (tcm_sel && wait_cfg == '0) |-> !tcm_wait);

  assert_req_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (tcm_sel && wait_cfg != '0) |-> tcm_wait);

  assert_final_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(tcm_wait) |=> (!tcm_wait || tcm_sel));

  assert_req_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tcm_sel |-> !$past(tcm_wait));

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    (!tcm_sel && !$past(tcm_wait)) |-> !tcm_wait);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(tcm_sel && !tcm_write) |=> $stable(tcm_rdata));
endmodule

bind tcm_slave tcm_slave_chk #(
  .WAIT_W (WAIT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tcm_sel   (tcm_sel),
  .tcm_write (tcm_write),
  .wait_cfg  (wait_cfg),
  .tcm_wait  (tcm_wait),
  .tcm_rdata (tcm_rdata)
);

// File: tb/tcm_slave_tb.sv
`timescale 1ns/1ps
module tcm_slave_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tcm_sel = 1'b0;
  logic [17:0] tcm_addr = '0;
  logic        tcm_write = 1'b0;
  logic [3:0]  tcm_lanes = '0;
  logic [31:0] tcm_wdata = '0;
  logic [2:0]  wait_cfg = '0;
  logic        tcm_wait;
  logic [31:0] tcm_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] model [1024];
  bit          pend = 1'b0;
  bit          pend_wr = 1'b0;
  logic [31:0] pend_val = '0;
  logic [31:0] last_rd = '0;

  always #2.5 clk = ~clk;

  tcm_slave u_dut (
    .clk(clk), .rst(rst), .tcm_sel(tcm_sel), .tcm_addr(tcm_addr),
    .tcm_write(tcm_write), .tcm_lanes(tcm_lanes), .tcm_wdata(tcm_wdata),
    .wait_cfg(wait_cfg), .tcm_wait(tcm_wait), .tcm_rdata(tcm_rdata)
  );

  function automatic int widx(input logic [17:0] a);
    return int'(a[11:2]);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old,
                                        input logic [31:0] d,
                                        input logic [3:0] ln);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++)
      if (ln[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // R6 R8: junk on every request-side input outside the request cycle
  task automatic scramble();
    tcm_sel   = 1'b0;
    tcm_addr  = 18'($urandom);
    tcm_write = 1'($urandom);
    tcm_lanes = 4'($urandom);
    tcm_wdata = $urandom;
    wait_cfg  = 3'($urandom);
  endtask

  task automatic settle();
    if (pend)
      chk(tcm_rdata === pend_val, pend_wr ? "R10 store kept rdata" : "R4 load data in closing cycle",
          tcm_rdata, pend_val);
    pend = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [17:0] a, input logic [3:0] ln,
                        input logic [31:0] d, input int w);
    logic [31:0] exp;
    @(negedge clk);
    tcm_sel = 1'b1; tcm_write = wr; tcm_addr = a;
    tcm_lanes = ln; tcm_wdata = d; wait_cfg = 3'(w);
    #1;
    settle();
    chk(tcm_wait === (w != 0), (w == 0) ? "R3 wait in request" : "R2 wait in request",
        32'(tcm_wait), 32'(w != 0));
    exp = model[widx(a)];
    if (wr) model[widx(a)] = merge(exp, d, ln);
    for (int k = 1; k <= w; k++) begin
      @(negedge clk);
      scramble();
      #1;
      chk(tcm_wait === (k < w), "R2 R8 wait pattern", 32'(tcm_wait), 32'(k < w));
      if (!wr) chk(tcm_rdata === exp, "R4 load data held", tcm_rdata, exp);
      else     chk(tcm_rdata === last_rd, "R10 store kept rdata", tcm_rdata, last_rd);
    end
    // the next cycle is the closing data cycle; a request may overlap it (R3)
    pend = 1'b1;
    pend_wr = wr;
    pend_val = wr ? last_rd : exp;
    if (!wr) last_rd = exp;
  endtask

  task automatic idle();
    @(negedge clk);
    scramble();
    #1;
    settle();
    chk(tcm_wait === 1'b0, "R9 wait low when idle", 32'(tcm_wait), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0107));
    repeat (4) @(negedge clk);
    #1;
    chk(tcm_wait === 1'b0, "R1 wait in reset", 32'(tcm_wait), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(tcm_wait === 1'b0, "R1 wait after reset", 32'(tcm_wait), 32'd0);
    chk(tcm_rdata === 32'd0, "R1 rdata after reset", tcm_rdata, 32'd0);

    // fill all words back to back with zero wait (R3)
    for (int i = 0; i < 1024; i++) begin
      model[i] = 32'hxxxx_xxxx;
      access(1'b1, 18'(i * 4), 4'hF, $urandom, 0);
    end
    idle();

    // R3: store then load of the same word, back to back at zero wait
    access(1'b1, 18'h00040, 4'hF, 32'h1357_9BDF, 0);
    access(1'b0, 18'h00040, 4'h0, 32'h0, 0);
    idle();
    chk(tcm_rdata === 32'h1357_9BDF, "R3 back-to-back read after write", tcm_rdata, 32'h1357_9BDF);

    // R5: partial lanes
    access(1'b1, 18'h00080, 4'hF, 32'hAABB_CCDD, 1);
    access(1'b1, 18'h00080, 4'b0101, 32'h1122_3344, 2);
    access(1'b0, 18'h00080, 4'h0, 32'h0, 3);
    idle();
    chk(tcm_rdata === 32'hAA22_CC44, "R5 disabled lanes kept", tcm_rdata, 32'hAA22_CC44);

    // R6: long store with junk on inputs during data cycles
    access(1'b1, 18'h00100, 4'hF, 32'hCAFE_F00D, 7);
    access(1'b0, 18'h00100, 4'h0, 32'h0, 0);
    idle();
    chk(tcm_rdata === 32'hCAFE_F00D, "R6 request-cycle capture", tcm_rdata, 32'hCAFE_F00D);

    // R7: aliasing through ignored address bits
    access(1'b1, 18'h00014, 4'hF, 32'h0BAD_BEEF, 0);
    access(1'b0, 18'h3F017, 4'h0, 32'h0, 4);
    idle();
    chk(tcm_rdata === 32'h0BAD_BEEF, "R7 upper and low bits ignored", tcm_rdata, 32'h0BAD_BEEF);

    // R10: a store after a load leaves rdata alone
    access(1'b1, 18'h00200, 4'hF, 32'h5555_AAAA, 2);
    idle();
    chk(tcm_rdata === 32'h0BAD_BEEF, "R10 rdata after store", tcm_rdata, 32'h0BAD_BEEF);

    // random mix, mostly back to back
    for (int n = 0; n < 3000; n++) begin
      access(1'($urandom), 18'($urandom), 4'($urandom), $urandom, $urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule